// File: doc/BRIEF.md
# Add/Subtract and Logical Flag Unit

This block is a purely combinational datapath slice. It takes two operands and produces a result together with the four condition flags that follow from it: negative, zero, carry and overflow. It adds with a carry-in, and it subtracts by adding the bitwise inverse of the second operand through the same adder. Because of this, the carry flag after a subtract means "no borrow", and a plain subtract is requested with a carry-in of 1.

A third mode passes an already computed logical value through unchanged. In that mode the carry flag is taken from an external shifter and overflow is left as it was. The caller supplies the current flags and decides whether the flags are updated at all. The flags register and any multiply logic sit outside the block.

Top module: `addsub_flag_unit`

## Requirements
- R1: With op_sel = 2'b00 (add), result equals op_a + op_b + carry_in, truncated to WIDTH bits.
- R2: With op_sel = 2'b01 (subtract), result equals op_a + ~op_b + carry_in, truncated to WIDTH bits, so carry_in = 1 gives op_a - op_b.
- R3: In add and subtract, the overflow flag is set exactly when both adder inputs (after inversion) share a sign bit and the result's sign bit differs from it.
- R4: In add and subtract, the carry flag is the carry out of the WIDTH-bit addition, so after a subtract with carry_in = 1 it is 1 when op_a >= op_b unsigned.
- R5: When flags are updated, the negative flag equals the result MSB and the zero flag is 1 only when every result bit is 0.
- R6: With op_sel[1] = 1 (logical pass-through, both 2'b10 and 2'b11), result equals op_a, op_b and carry_in have no effect, the carry flag takes shift_carry and the overflow flag keeps flags_in's value.
- R7: When set_flags = 0, flags_out equals flags_in in every mode, while result is still computed.
- R8: Flag vectors are packed as bit 3 = negative, bit 2 = zero, bit 1 = carry, bit 0 = overflow, on both flags_in and flags_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand, or the logical value in pass-through mode |
| op_b | input | WIDTH | Second operand (ignored in pass-through mode) |
| carry_in | input | 1 | Carry into the adder |
| op_sel | input | 2 | 00 add, 01 subtract, 1x logical pass-through |
| set_flags | input | 1 | 1 updates the flags, 0 holds them |
| shift_carry | input | 1 | Carry-out of the external shifter, used in pass-through mode |
| flags_in | input | 4 | Current flags {N, Z, C, V} |
| result | output | WIDTH | Computed result |
| flags_out | output | 4 | Next flags {N, Z, C, V} |

## Verification
The hardest situations to reach are those where carry and overflow disagree, such as the most negative value minus one (carry set, overflow set, result positive) or two most negative values added (zero, carry and overflow all set together). The stimulus table places operands exactly on the sign boundary in both add and subtract, and drives subtract with carry_in = 0 as well as 1. Pass-through entries carry a nonzero op_b and a held overflow bit so that an unwanted dependency shows at the flag outputs.

// File: rtl/addsub_flag_pkg.sv
package addsub_flag_pkg;

    typedef enum logic [1:0] {
        OP_ADD   = 2'b00,
        OP_SUB   = 2'b01,
        OP_LOGIC = 2'b10,
        OP_LOGX  = 2'b11
    } asf_op_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } asf_flags_t;

endpackage

// File: rtl/asf_operand_prep.sv
module asf_operand_prep #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] b_in,
    input  logic             invert,
    output logic [WIDTH-1:0] b_eff
);
    typedef struct packed {
        logic [WIDTH-1:0] b_eff;
    } prep_t;

    prep_t prep_d;

    always_comb begin
        prep_d.b_eff = invert ? ~b_in : b_in;
    end

    assign b_eff = prep_d.b_eff;
endmodule

// File: rtl/asf_adder.sv
module asf_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             carry,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH:0] wide;
        logic [WIDTH-1:0] ovf_mask;
    } add_t;

    add_t add_d;

    always_comb begin
        add_d.wide     = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        add_d.ovf_mask = ~(a ^ b) & (a ^ add_d.wide[MSB:0]);
    end

    assign sum   = add_d.wide[MSB:0];
    assign carry = add_d.wide[WIDTH];
    assign ovf   = add_d.ovf_mask[MSB];

    always_comb begin
        // R4
        carry_formula_chk: assert (carry == (a[MSB] ^ b[MSB] ^ ovf ^ sum[MSB]))
            else $error("carry-out disagrees with sign-bit formula");
        // R3
        if (ovf) begin
            ovf_sign_chk: assert ((a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]))
                else $error("overflow without sign change");
        end
    end
endmodule

// File: rtl/asf_flag_select.sv
module asf_flag_select #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]              res,
    input  logic                          logic_mode,
    input  logic                          update,
    input  logic                          add_carry,
    input  logic                          add_ovf,
    input  logic                          shift_carry,
    input  addsub_flag_pkg::asf_flags_t   cur,
    output addsub_flag_pkg::asf_flags_t   nxt
);
    import addsub_flag_pkg::*;

    asf_flags_t nxt_d;

    always_comb begin
        nxt_d = cur;
        if (update) begin
            nxt_d.n = res[WIDTH-1];
            nxt_d.z = (res == '0);
            if (logic_mode) begin
                nxt_d.c = shift_carry;
            end else begin
                nxt_d.c = add_carry;
                nxt_d.v = add_ovf;
            end
        end
    end

    assign nxt = nxt_d;
endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic [1:0]       op_sel,
    input  logic             set_flags,
    input  logic             shift_carry,
    input  logic [3:0]       flags_in,
    output logic [WIDTH-1:0] result,
    output logic [3:0]       flags_out
);
    import addsub_flag_pkg::*;

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic             is_logic;
        logic             is_sub;
        logic [WIDTH-1:0] result;
    } top_t;

    top_t             top_d;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] add_sum;
    logic             add_carry;
    logic             add_ovf;
    asf_flags_t       cur_flags;
    asf_flags_t       nxt_flags;

    always_comb begin
        top_d.is_logic = op_sel[1];
        top_d.is_sub   = (op_sel == OP_SUB);
    end

    asf_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .b_in   (op_b),
        .invert (top_d.is_sub),
        .b_eff  (b_eff)
    );

    asf_adder #(.WIDTH(WIDTH)) u_adder (
        .a     (op_a),
        .b     (b_eff),
        .cin   (carry_in),
        .sum   (add_sum),
        .carry (add_carry),
        .ovf   (add_ovf)
    );

    always_comb begin
        top_d.result = top_d.is_logic ? op_a : add_sum;
    end

    assign cur_flags = flags_in;

    asf_flag_select #(.WIDTH(WIDTH)) u_flags (
        .res         (top_d.result),
        .logic_mode  (top_d.is_logic),
        .update      (set_flags),
        .add_carry   (add_carry),
        .add_ovf     (add_ovf),
        .shift_carry (shift_carry),
        .cur         (cur_flags),
        .nxt         (nxt_flags)
    );

    assign result    = top_d.result;
    assign flags_out = nxt_flags;

    always_comb begin
        if (set_flags) begin
            // R5
            nz_track_chk: assert ((flags_out[FLAG_N] == result[MSB]) &&
                                  (flags_out[FLAG_Z] == (result == '0)))
                else $error("N/Z do not follow result");
        end
        if (op_sel[1]) begin
            // R6
            logic_v_hold_chk: assert (flags_out[FLAG_V] == flags_in[FLAG_V])
                else $error("overflow changed in pass-through mode");
            // R6
            logic_pass_chk: assert (result == op_a)
                else $error("pass-through result differs from op_a");
        end
    end
endmodule

// File: tb/addsub_flag_unit_bench.sv
module addsub_flag_unit_bench;
    localparam int W = 32;

    typedef struct packed {
        logic [1:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         cin;
        logic         setf;
        logic         shc;
        logic [3:0]   fin;
        logic [W-1:0] res;
        logic [3:0]   fout;
    } vec_t;

    localparam int NV = 15;
    // flags packed {N,Z,C,V}; op 0 add, 1 sub, 2/3 pass-through
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 4'h0, 32'h0000_0002, 4'h0}, // R1
        '{2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 4'h0, 32'h0000_0000, 4'h6}, // R4 R5
        '{2'd0, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 4'h0, 32'h8000_0000, 4'h9}, // R3
        '{2'd0, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 4'h0, 32'h0000_0000, 4'h7}, // R3 R4
        '{2'd0, 32'h0000_0005, 32'h0000_0006, 1'b1, 1'b1, 1'b0, 4'hF, 32'h0000_000C, 4'h0}, // R1 carry-in
        '{2'd1, 32'h0000_0005, 32'h0000_0003, 1'b1, 1'b1, 1'b0, 4'h0, 32'h0000_0002, 4'h2}, // R2 R4
        '{2'd1, 32'h0000_0003, 32'h0000_0005, 1'b1, 1'b1, 1'b0, 4'h2, 32'hFFFF_FFFE, 4'h8}, // R2 borrow
        '{2'd1, 32'h0000_0005, 32'h0000_0005, 1'b1, 1'b1, 1'b0, 4'h0, 32'h0000_0000, 4'h6}, // R2 R5
        '{2'd1, 32'h8000_0000, 32'h0000_0001, 1'b1, 1'b1, 1'b0, 4'h0, 32'h7FFF_FFFF, 4'h3}, // R3 R4
        '{2'd1, 32'h0000_0005, 32'h0000_0003, 1'b0, 1'b1, 1'b0, 4'h0, 32'h0000_0001, 4'h2}, // R2 cin 0
        '{2'd2, 32'h8000_0000, 32'h0000_FFFF, 1'b1, 1'b1, 1'b1, 4'h1, 32'h8000_0000, 4'hB}, // R6
        '{2'd2, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 4'h3, 32'h0000_0000, 4'h5}, // R6 V held
        '{2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 4'h9, 32'h0000_0000, 4'h9}, // R7
        '{2'd2, 32'h0000_0012, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 4'h6, 32'h0000_0012, 4'h6}, // R7
        '{2'd3, 32'h0000_0040, 32'h1234_5678, 1'b1, 1'b1, 1'b1, 4'h0, 32'h0000_0040, 4'h2}  // R6 R8
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic         set_flags = 1'b0;
    logic         shift_carry = 1'b0;
    logic [3:0]   flags_in = 4'h0;
    logic [W-1:0] result;
    logic [3:0]   flags_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    addsub_flag_unit #(.WIDTH(W)) u_addsub_flag_unit (
        .op_a        (op_a),
        .op_b        (op_b),
        .carry_in    (carry_in),
        .op_sel      (op_sel),
        .set_flags   (set_flags),
        .shift_carry (shift_carry),
        .flags_in    (flags_in),
        .result      (result),
        .flags_out   (flags_out)
    );

    task automatic drive(input vec_t v);
        @(negedge clk);
        op_sel      = v.op;
        op_a        = v.a;
        op_b        = v.b;
        carry_in    = v.cin;
        set_flags   = v.setf;
        shift_carry = v.shc;
        flags_in    = v.fin;
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input vec_t v);
        checks++;
        if (result !== v.res || flags_out !== v.fout) begin
            fails++;
            $display("FAIL %s: result=%h flags=%h expected result=%h flags=%h",
                     tag, result, flags_out, v.res, v.fout);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        vec_t idle;
        vec_t v;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #2;
        // R5 idle/reset state: all-zero inputs, flags held at 0 since set_flags=0
        idle = '{2'd0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 4'h0, 32'h0, 4'h0};
        check("R7 reset idle", idle);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            check($sformatf("vector %0d (R1..R8 table)", i), VECS[i]);
        end

        // R6: op_b and carry_in have no effect in pass-through
        v = '{2'd2, 32'h0000_0000, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 4'h0, 32'h0, 4'h4};
        drive(v);
        check("R6 op_b ignored", v);
        // R8: all flag bits held set when update off in subtract
        v = '{2'd1, 32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 4'hF, 32'h0, 4'hF};
        drive(v);
        check("R8 hold all ones", v);
        // R4: subtract of zero with carry-in 1 produces carry (no borrow)
        v = '{2'd1, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 4'h0, 32'h0, 4'h6};
        drive(v);
        check("R4 zero minus zero", v);
        // R1: max plus max plus carry wraps with carry
        v = '{2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 4'h0, 32'hFFFF_FFFF, 4'hA};
        drive(v);
        check("R1 max wrap", v);

        done = 1'b1;
        finish_run();
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: run hung, cycles=%0d expected < 5000", cyc);
                finish_run();
            end
        end
    end
endmodule